// File: doc/BRIEF.md
# Fault-Only-First Vector Length Truncation Unit

This unit settles the architectural result of a fault-only-first unit-stride vector load. When the load issues, the unit records the requested vector length. It then takes in the memory system's per-element exception responses, which can arrive in any order, and tracks the lowest-numbered element that reported a fault, along with that element's cause code. When the memory side signals that every response is in, the unit chooses one of three outcomes:

- **Trap.** Element 0 faulted, so a precise trap is raised.
- **Truncate.** A later element faulted. No trap is taken, and a shortened vector length equal to that element's index is committed.
- **Complete.** Nothing faulted, so the instruction finishes with its length unchanged.

Together with the outcome, the unit drives a per-element write-enable vector. The register-file write path uses it to drop data for elements at or beyond the truncation point.

The control is a five-state machine:

- **IDLE** moves to **COLLECT** when `start_i` is seen.
- **COLLECT** stays put until `all_rsp_i` is high. It then moves to one of three states:
  - **TRAP** if element 0 faulted.
  - **TRUNC** if only later elements faulted.
  - **DONE** if nothing faulted.
- **TRAP** stays put until `trap_ack_i` is seen, then returns to **IDLE**.
- **TRUNC** and **DONE** each last one cycle and return to **IDLE**.

The vector-length write pulse appears only in TRUNC. Configuration instructions are the only other writer of vector length.

Top module: `fof_vl_trunc`

## Requirements
- R1: After reset the unit is idle: `busy_o`, `trap_o`, `vl_we_o`, `done_o` are 0 and `elem_wen_o` is all zero.
- R2: If element 0 reports a fault, the unit raises `trap_o` with `trap_elem_o` = 0 and `trap_cause_o` equal to element 0's cause code. In the same cycle it drives `vl_we_o` = 0 and `elem_wen_o` = 0.
- R3: `trap_o` and `trap_cause_o` hold steady until `trap_ack_i` is sampled high. In the cycle after that, `trap_o` and `busy_o` are 0.
- R4: If the lowest faulting element k is greater than 0, `vl_we_o` pulses for exactly one cycle with `vl_new_o` = k. No trap is raised.
- R5: The truncated length is the lowest faulting index whatever the arrival order of the responses, including when they arrive in descending index order.
- R6: If no element faults, `done_o` pulses for one cycle, `vl_we_o` stays 0, and `elem_wen_o` bit i is 1 exactly for i < starting vl.
- R7: On truncation, `elem_wen_o` bit i is 1 for i < k and 0 for i ≥ k.
- R8: No outcome is produced before `all_rsp_i` is sampled high while collecting. The outcome appears in the cycle after that sample, and it includes a response given in the same cycle as `all_rsp_i`.
- R9: A response whose element index is at or above the starting vl, or whose fault bit is 0, has no effect on the outcome.
- R10: At most one of `trap_o`, `vl_we_o`, `done_o` is high in any cycle. Any committed `vl_new_o` is nonzero and below the starting vl.
- R11: A `start_i` given while `busy_o` is high is ignored, and the running instruction keeps its original starting vl.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new fault-only-first load (accepted only when idle) |
| start_vl_i | input | VL_W | Requested vector length |
| rsp_valid_i | input | 1 | One element response this cycle |
| rsp_idx_i | input | IDX_W | Element index of the response |
| rsp_fault_i | input | 1 | The element raised an exception |
| rsp_cause_i | input | CAUSE_W | Exception cause code |
| all_rsp_i | input | 1 | All element responses have been delivered |
| trap_ack_i | input | 1 | Trap has been taken; release it |
| busy_o | output | 1 | Instruction in progress |
| trap_o | output | 1 | Precise trap on element 0 |
| trap_elem_o | output | IDX_W | Faulting element of the trap |
| trap_cause_o | output | CAUSE_W | Cause code of the trap |
| vl_we_o | output | 1 | Commit truncated vector length |
| vl_new_o | output | VL_W | Truncated vector length |
| done_o | output | 1 | Normal completion, length unchanged |
| elem_wen_o | output | MAX_VL | Per-element write enable for the result |

## Verification
The bound checker enforces, on every cycle:
- the mutual exclusion of the three outcomes;
- the one-cycle shape of the commit pulse;
- trap holding until acknowledge;
- the rule that a committed length lies strictly inside the original one;
- agreement between the write-enable population and the committed or original length;
- the rule that no outcome appears without a preceding all-responses indication.

Only the bench scenarios can show that the chosen length is the lowest faulting index, because that needs the actual fault pattern. The same holds for showing that out-of-range or non-fault responses change nothing, and that a start request during a busy period leaves the captured length intact. To cover these, the bench sweeps every single-fault position for every length, and every fault pattern at one length with descending arrival.

// File: rtl/fof_pkg.sv
package fof_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_COLLECT = 3'd1,
        ST_TRAP    = 3'd2,
        ST_TRUNC   = 3'd3,
        ST_DONE    = 3'd4
    } fof_state_e;

endpackage

// File: rtl/fof_min_tracker.sv
// Keeps the lowest faulting element index seen since the last clear,
// together with its cause code. Also presents the next-state view so the
// controller can decide in the same cycle a final response arrives.
module fof_min_tracker #(
    parameter int IDX_W   = 4,
    parameter int VL_W    = 5,
    parameter int CAUSE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               enable_i,
    input  logic [VL_W-1:0]    limit_i,
    input  logic               rsp_valid_i,
    input  logic               rsp_fault_i,
    input  logic [IDX_W-1:0]   rsp_idx_i,
    input  logic [CAUSE_W-1:0] rsp_cause_i,
    output logic               have_q,
    output logic [IDX_W-1:0]   idx_q,
    output logic [CAUSE_W-1:0] cause_q,
    output logic               have_nxt,
    output logic [IDX_W-1:0]   idx_nxt
);

    logic in_range;
    logic lower;
    logic take;

    always_comb begin
        in_range = VL_W'(rsp_idx_i) < limit_i;
        lower    = !have_q || (rsp_idx_i < idx_q);
        take     = enable_i && rsp_valid_i && rsp_fault_i && in_range && lower;
        have_nxt = have_q || take;
        idx_nxt  = take ? rsp_idx_i : idx_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_q  <= 1'b0;
            idx_q   <= '0;
            cause_q <= '0;
        end else if (clear_i) begin
            have_q  <= 1'b0;
            idx_q   <= '0;
            cause_q <= '0;
        end else if (take) begin
            have_q  <= 1'b1;
            idx_q   <= rsp_idx_i;
            cause_q <= rsp_cause_i;
        end
    end

endmodule

// File: rtl/fof_wen_mask.sv
// Thermometer write-enable: bit i set when i is below the limit.
module fof_wen_mask #(
    parameter int MAX_VL = 16,
    parameter int VL_W   = 5
) (
    input  logic [VL_W-1:0]   limit_i,
    output logic [MAX_VL-1:0] mask_o
);

    for (genvar i = 0; i < MAX_VL; i++) begin : g_bit
        assign mask_o[i] = limit_i > VL_W'(i);
    end

endmodule

// File: rtl/fof_vl_trunc.sv
module fof_vl_trunc #(
    parameter  int MAX_VL  = 16,
    parameter  int CAUSE_W = 6,
    localparam int VL_W    = $clog2(MAX_VL + 1),
    localparam int IDX_W   = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [VL_W-1:0]    start_vl_i,
    input  logic               rsp_valid_i,
    input  logic [IDX_W-1:0]   rsp_idx_i,
    input  logic               rsp_fault_i,
    input  logic [CAUSE_W-1:0] rsp_cause_i,
    input  logic               all_rsp_i,
    input  logic               trap_ack_i,
    output logic               busy_o,
    output logic               trap_o,
    output logic [IDX_W-1:0]   trap_elem_o,
    output logic [CAUSE_W-1:0] trap_cause_o,
    output logic               vl_we_o,
    output logic [VL_W-1:0]    vl_new_o,
    output logic               done_o,
    output logic [MAX_VL-1:0]  elem_wen_o
);

    import fof_pkg::*;

    fof_state_e         state_q, state_d;
    logic [VL_W-1:0]    vl_q;
    logic               accept;
    logic               have_q, have_nxt;
    logic [IDX_W-1:0]   idx_q, idx_nxt;
    logic [CAUSE_W-1:0] cause_q;
    logic [VL_W-1:0]    mask_limit;
    logic [MAX_VL-1:0]  mask;

    assign accept = (state_q == ST_IDLE) && start_i;

    fof_min_tracker #(
        .IDX_W  (IDX_W),
        .VL_W   (VL_W),
        .CAUSE_W(CAUSE_W)
    ) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (accept),
        .enable_i   (state_q == ST_COLLECT),
        .limit_i    (vl_q),
        .rsp_valid_i(rsp_valid_i),
        .rsp_fault_i(rsp_fault_i),
        .rsp_idx_i  (rsp_idx_i),
        .rsp_cause_i(rsp_cause_i),
        .have_q     (have_q),
        .idx_q      (idx_q),
        .cause_q    (cause_q),
        .have_nxt   (have_nxt),
        .idx_nxt    (idx_nxt)
    );

    fof_wen_mask #(
        .MAX_VL(MAX_VL),
        .VL_W  (VL_W)
    ) u_mask (
        .limit_i(mask_limit),
        .mask_o (mask)
    );

    // State register and captured starting length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vl_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                vl_q <= start_vl_i;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (all_rsp_i) begin
                    if (!have_nxt) begin
                        state_d = ST_DONE;
                    end else if (idx_nxt == '0) begin
                        state_d = ST_TRAP;
                    end else begin
                        state_d = ST_TRUNC;
                    end
                end
            end
            ST_TRAP: begin
                if (trap_ack_i) begin
                    state_d = ST_IDLE;
                end
            end
            ST_TRUNC: state_d = ST_IDLE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        busy_o       = 1'b1;
        trap_o       = 1'b0;
        trap_elem_o  = '0;
        trap_cause_o = '0;
        vl_we_o      = 1'b0;
        vl_new_o     = '0;
        done_o       = 1'b0;
        mask_limit   = '0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
            end
            ST_COLLECT: begin
                busy_o = 1'b1;
            end
            ST_TRAP: begin
                trap_o       = 1'b1;
                trap_elem_o  = idx_q;
                trap_cause_o = cause_q;
            end
            ST_TRUNC: begin
                vl_we_o    = have_q;
                vl_new_o   = VL_W'(idx_q);
                mask_limit = VL_W'(idx_q);
            end
            ST_DONE: begin
                done_o     = 1'b1;
                mask_limit = vl_q;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
        elem_wen_o = mask;
    end

endmodule

// File: rtl/fof_vl_trunc_chk.sv
module fof_vl_trunc_chk #(
    parameter  int MAX_VL  = 16,
    parameter  int CAUSE_W = 6,
    localparam int VL_W    = $clog2(MAX_VL + 1),
    localparam int IDX_W   = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [VL_W-1:0]    start_vl_i,
    input logic               all_rsp_i,
    input logic               trap_ack_i,
    input logic               busy_o,
    input logic               trap_o,
    input logic [IDX_W-1:0]   trap_elem_o,
    input logic [CAUSE_W-1:0] trap_cause_o,
    input logic               vl_we_o,
    input logic [VL_W-1:0]    vl_new_o,
    input logic               done_o,
    input logic [MAX_VL-1:0]  elem_wen_o
);

    logic [VL_W-1:0] chk_vl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_vl <= '0;
        end else if (start_i && !busy_o) begin
            chk_vl <= start_vl_i;
        end
    end

    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_o, vl_we_o, done_o}));

    assert_vl_inside_R10: assert property (@(posedge clk) disable iff (!rst_n)
        vl_we_o |-> (vl_new_o != '0) && (vl_new_o < chk_vl));

    assert_trap_elem_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (trap_elem_o == '0) && (elem_wen_o == '0));

    assert_trap_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && !trap_ack_i) |=> trap_o && $stable(trap_cause_o));

    assert_trap_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && trap_ack_i) |=> !trap_o);

    assert_commit_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vl_we_o |=> !vl_we_o);

    assert_trunc_wen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vl_we_o |-> ($countones(elem_wen_o) == int'(vl_new_o)));

    assert_done_wen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($countones(elem_wen_o) == int'(chk_vl)) && !vl_we_o);

    assert_wait_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(trap_o) || vl_we_o || done_o) |-> $past(all_rsp_i));

endmodule

bind fof_vl_trunc fof_vl_trunc_chk #(
    .MAX_VL (MAX_VL),
    .CAUSE_W(CAUSE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_vl_i  (start_vl_i),
    .all_rsp_i   (all_rsp_i),
    .trap_ack_i  (trap_ack_i),
    .busy_o      (busy_o),
    .trap_o      (trap_o),
    .trap_elem_o (trap_elem_o),
    .trap_cause_o(trap_cause_o),
    .vl_we_o     (vl_we_o),
    .vl_new_o    (vl_new_o),
    .done_o      (done_o),
    .elem_wen_o  (elem_wen_o)
);

// File: tb/tb_fof_vl_trunc.sv
`timescale 1ns/1ps
module tb_fof_vl_trunc;

    localparam int MAX_VL  = 16;
    localparam int CAUSE_W = 6;
    localparam int VL_W    = $clog2(MAX_VL + 1);
    localparam int IDX_W   = $clog2(MAX_VL);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_i = 1'b0;
    logic [VL_W-1:0]    start_vl_i = '0;
    logic               rsp_valid_i = 1'b0;
    logic [IDX_W-1:0]   rsp_idx_i = '0;
    logic               rsp_fault_i = 1'b0;
    logic [CAUSE_W-1:0] rsp_cause_i = '0;
    logic               all_rsp_i = 1'b0;
    logic               trap_ack_i = 1'b0;
    logic               busy_o, trap_o, vl_we_o, done_o;
    logic [IDX_W-1:0]   trap_elem_o;
    logic [CAUSE_W-1:0] trap_cause_o;
    logic [VL_W-1:0]    vl_new_o;
    logic [MAX_VL-1:0]  elem_wen_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    fof_vl_trunc #(.MAX_VL(MAX_VL), .CAUSE_W(CAUSE_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_vl_i(start_vl_i),
        .rsp_valid_i(rsp_valid_i), .rsp_idx_i(rsp_idx_i), .rsp_fault_i(rsp_fault_i),
        .rsp_cause_i(rsp_cause_i), .all_rsp_i(all_rsp_i), .trap_ack_i(trap_ack_i),
        .busy_o(busy_o), .trap_o(trap_o), .trap_elem_o(trap_elem_o),
        .trap_cause_o(trap_cause_o), .vl_we_o(vl_we_o), .vl_new_o(vl_new_o),
        .done_o(done_o), .elem_wen_o(elem_wen_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int cause_of(input int idx);
        return (idx + 3) % (1 << CAUSE_W);
    endfunction

    // One instruction: vl elements, fault bit per element from fmask,
    // optional descending arrival, optional final response with all_rsp,
    // optional start poke while busy.
    task automatic run_op(input int vl, input int fmask, input bit desc,
                          input bit same_cycle, input bit poke);
        int eff;
        int k;
        bit joint;
        string tag;
        eff   = fmask & ((1 << vl) - 1);
        joint = same_cycle && (vl > 0);
        tag   = poke ? "R11" : (desc ? "R5" : "R4");
        @(negedge clk);
        start_i = 1'b1; start_vl_i = VL_W'(vl);
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            start_i = 1'b1; start_vl_i = VL_W'(1);
            @(negedge clk);
            start_i = 1'b0;
            chk(busy_o == 1'b1, "R11 busy kept", int'(busy_o), 1);
        end
        for (int j = 0; j < vl; j++) begin
            int idx;
            idx = desc ? (vl - 1 - j) : j;
            rsp_valid_i = 1'b1;
            rsp_idx_i   = IDX_W'(idx);
            rsp_fault_i = eff[idx];
            rsp_cause_i = CAUSE_W'(cause_of(idx));
            if (joint && j == vl - 1) all_rsp_i = 1'b1;
            @(negedge clk);
            if (!(joint && j == vl - 1))
                chk(!trap_o && !vl_we_o && !done_o, "R8 early",
                    int'({trap_o, vl_we_o, done_o}), 0);
        end
        rsp_valid_i = 1'b0;
        if (!joint) begin
            if (vl < MAX_VL) begin
                rsp_valid_i = 1'b1; rsp_idx_i = IDX_W'(vl); rsp_fault_i = 1'b1;
                rsp_cause_i = CAUSE_W'(cause_of(vl));
                @(negedge clk);
                rsp_valid_i = 1'b0;
            end
            // non-fault response to element 0 is harmless
            rsp_valid_i = 1'b1; rsp_idx_i = '0; rsp_fault_i = 1'b0;
            rsp_cause_i = CAUSE_W'(7);
            all_rsp_i = 1'b1;
            @(negedge clk);
            rsp_valid_i = 1'b0;
        end
        all_rsp_i = 1'b0;
        rsp_fault_i = 1'b0;
        if (eff[0]) begin
            chk(trap_o == 1'b1, "R2 trap", int'(trap_o), 1);
            chk(int'(trap_cause_o) == cause_of(0), "R2 cause", int'(trap_cause_o), cause_of(0));
            chk(trap_elem_o == '0, "R2 elem", int'(trap_elem_o), 0);
            chk(elem_wen_o == '0 && !vl_we_o, "R2 no write", int'(elem_wen_o), 0);
            @(negedge clk);
            chk(trap_o == 1'b1 && int'(trap_cause_o) == cause_of(0), "R3 hold",
                int'(trap_cause_o), cause_of(0));
            trap_ack_i = 1'b1;
            @(negedge clk);
            trap_ack_i = 1'b0;
            chk(!trap_o && !busy_o, "R3 release", int'({trap_o, busy_o}), 0);
        end else if (eff != 0) begin
            k = 0;
            while (!eff[k]) k++;
            chk(vl_we_o == 1'b1 && !trap_o && !done_o, {tag, " commit"},
                int'({trap_o, vl_we_o, done_o}), 2);
            chk(int'(vl_new_o) == k, {tag, " vl_new"}, int'(vl_new_o), k);
            chk(int'(elem_wen_o) == (1 << k) - 1, "R7 wen", int'(elem_wen_o), (1 << k) - 1);
            @(negedge clk);
            chk(!vl_we_o, "R4 pulse", int'(vl_we_o), 0);
        end else begin
            chk(done_o == 1'b1 && !vl_we_o && !trap_o, poke ? "R11 done" : "R6 done",
                int'({trap_o, vl_we_o, done_o}), 1);
            chk(int'(elem_wen_o) == (1 << vl) - 1, poke ? "R11 wen" : "R6 wen",
                int'(elem_wen_o), (1 << vl) - 1);
            @(negedge clk);
            chk(!done_o, "R6 pulse", int'(done_o), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !trap_o && !vl_we_o && !done_o && elem_wen_o == '0, "R1 reset",
            int'({busy_o, trap_o, vl_we_o, done_o}), 0);

        // every length, no fault and each single fault position
        for (int vl = 0; vl <= MAX_VL; vl++) begin
            run_op(vl, 0, 1'b0, 1'b0, 1'b0);
            for (int k = 0; k < vl; k++)
                run_op(vl, 1 << k, k[0], (k % 3) == 0, 1'b0);
        end
        // every fault pattern at length 8, descending arrival (R5, R9)
        for (int m = 0; m < 256; m++)
            run_op(8, m | 32'h300, 1'b1, m[0], 1'b0);
        // scattered multi-fault patterns at full length
        for (int s = 1; s <= 64; s++)
            run_op(MAX_VL, (s * 40503) & 16'hFFFF, s[0], s[1], 1'b0);
        // start while busy ignored (R11)
        run_op(12, 1 << 9, 1'b0, 1'b0, 1'b1);
        run_op(5, 0, 1'b0, 1'b0, 1'b1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule